// File: doc/BRIEF.md
# Timed Interrupt-Level Override Window

This unit lets a single prefix instruction take over the interrupt priority level for a fixed run of the instructions that follow it. The prefix carries a packed immediate of eleven 3-bit level fields. Each time a following instruction is enqueued, the unit hands out the next field as that instruction's effective interrupt level. When the run is over, the level that was in force before the prefix comes back without any further instructions.

The unit sits beside the enqueue stage. A strobe marks the prefix and supplies its immediate. A second strobe marks each enqueued instruction. The architectural interrupt level is an input, and a flush cancels the run. The unit outputs the effective level and a flag that is high while a run is open. It also gives a one-cycle restore pulse that carries the saved level. A small gate compares an incoming interrupt request against the effective level, so that masked requests are held off.

Top module: `ipl_override_window`

## Requirements
- R1: After reset, `win_open` and `restore_vld` are 0 and `eff_lvl` equals `arch_lvl`.
- R2: While no window is open, `eff_lvl` follows `arch_lvl` in the same cycle.
- R3: A cycle with `pfx_vld` high and `flush` low opens a window of 11 slots. Slot k (k = 0 for the first) uses the immediate bits [3k+2:3k]. Slot k is shown on `eff_lvl` while the k-th instruction after the prefix is being enqueued.
- R4: An enqueue in the last slot closes the window. From the next cycle, `win_open` is 0 and `eff_lvl` follows `arch_lvl` again.
- R5: In the cycle after a window closes, `restore_vld` is high for exactly one cycle. `restore_lvl` then carries the value that `arch_lvl` had when the first prefix of that window was accepted.
- R6: An `enq_vld` in the same cycle as `pfx_vld` does not use a slot. A cycle without `enq_vld` does not advance the window.
- R7: A prefix that arrives inside an open window restarts a full 11-slot window with its own immediate. The level saved by the first prefix is kept for the restore.
- R8: `flush` has priority over everything else. It closes an open window from the next cycle and gives the restore pulse one cycle later. A prefix in the same cycle as a flush is ignored. A flush with no window open gives no pulse.
- R9: `irq_take` is high when `nmi` is high, or when `irq_vld` is high and `irq_prio` is above `eff_lvl` (unsigned). A level of 7 therefore blocks every request except the non-maskable one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfx_vld | input | 1 | Override prefix detected this cycle |
| pfx_imm | input | 33 | Packed per-slot levels, slot 0 in the low bits |
| enq_vld | input | 1 | One instruction enqueued this cycle |
| arch_lvl | input | 3 | Architectural interrupt level |
| flush | input | 1 | Pipeline flush |
| irq_vld | input | 1 | Maskable interrupt request |
| irq_prio | input | 3 | Priority of the maskable request |
| nmi | input | 1 | Non-maskable interrupt request |
| eff_lvl | output | 3 | Effective interrupt level for the current instruction |
| win_open | output | 1 | Override window active |
| restore_vld | output | 1 | One-cycle restore pulse |
| restore_lvl | output | 3 | Level to restore, valid with the pulse |
| irq_take | output | 1 | Interrupt may be taken now |

## Verification
The bench targets the last slot of a window. A design with an off-by-one in the slot count would close the window after 10 or 12 enqueues, or would show a stale field for the eleventh. Nested prefixes are checked: a design that saves the level again on the second prefix would restore the override value instead of the original level. Enqueues in the same cycle as a prefix, and idle cycles inside a window, are applied, because a design that counts them would shift the fields out of step. The bench also drives a flush together with a prefix and a flush with no window open, which catches a wrong priority or a spurious restore pulse. Requests at priorities equal to the effective level and against level 7 expose a `>=` written in place of `>` and a gate that masks the non-maskable request.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
  localparam int unsigned LVL_W = 3;
  localparam int unsigned SLOTS = 11;

  // pick slot k out of a packed immediate
  function automatic logic [LVL_W-1:0] slot_lvl(input logic [LVL_W*SLOTS-1:0] imm,
                                                input int unsigned k);
    return imm[k*LVL_W +: LVL_W];
  endfunction

  // a request passes only when strictly above the mask level
  function automatic logic prio_above(input logic [LVL_W-1:0] prio,
                                      input logic [LVL_W-1:0] lvl);
    return prio > lvl;
  endfunction
endpackage

// File: rtl/ipl_slot_seq.sv
module ipl_slot_seq #(
  parameter int unsigned LVL_W = ipl_pkg::LVL_W,
  parameter int unsigned SLOTS = ipl_pkg::SLOTS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [LVL_W*SLOTS-1:0] load_imm,
  input  logic                   advance,
  input  logic                   kill,
  output logic                   active,
  output logic [LVL_W-1:0]       cur_lvl,
  output logic                   last_adv
);
  localparam int unsigned IMM_W = LVL_W * SLOTS;
  localparam int unsigned CNT_W = $clog2(SLOTS + 1);

  logic [IMM_W-1:0] shreg;
  logic [CNT_W-1:0] remain;

  assign active   = (remain != '0);
  assign cur_lvl  = ipl_pkg::slot_lvl(shreg, 0);
  assign last_adv = advance && active && (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      remain <= '0;
    end else if (kill) begin
      shreg  <= '0;
      remain <= '0;
    end else if (load) begin
      shreg  <= load_imm;
      remain <= CNT_W'(SLOTS);
    end else if (advance && active) begin
      shreg  <= shreg >> LVL_W;
      remain <= remain - CNT_W'(1);
    end
  end
endmodule

// File: rtl/ipl_save_restore.sv
module ipl_save_restore #(
  parameter int unsigned LVL_W = ipl_pkg::LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [LVL_W-1:0] lvl_in,
  input  logic             close_evt,
  output logic             restore_vld,
  output logic [LVL_W-1:0] restore_lvl
);
  logic [LVL_W-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held        <= '0;
      restore_vld <= 1'b0;
      restore_lvl <= '0;
    end else begin
      if (capture) held <= lvl_in;
      restore_vld <= close_evt;
      if (close_evt) restore_lvl <= held;
    end
  end
endmodule

// File: rtl/ipl_irq_gate.sv
module ipl_irq_gate #(
  parameter int unsigned LVL_W = ipl_pkg::LVL_W
) (
  input  logic             irq_vld,
  input  logic [LVL_W-1:0] irq_prio,
  input  logic             nmi,
  input  logic [LVL_W-1:0] mask_lvl,
  output logic             take
);
  assign take = nmi || (irq_vld && ipl_pkg::prio_above(irq_prio, mask_lvl));
endmodule

// File: rtl/ipl_override_window.sv
module ipl_override_window #(
  parameter int unsigned LVL_W = ipl_pkg::LVL_W,
  parameter int unsigned SLOTS = ipl_pkg::SLOTS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pfx_vld,
  input  logic [LVL_W*SLOTS-1:0] pfx_imm,
  input  logic                   enq_vld,
  input  logic [LVL_W-1:0]       arch_lvl,
  input  logic                   flush,
  input  logic                   irq_vld,
  input  logic [LVL_W-1:0]       irq_prio,
  input  logic                   nmi,
  output logic [LVL_W-1:0]       eff_lvl,
  output logic                   win_open,
  output logic                   restore_vld,
  output logic [LVL_W-1:0]       restore_lvl,
  output logic                   irq_take
);
  // named internal events, used by the checker
  logic             load_evt;
  logic             adv_evt;
  logic             capture_evt;
  logic             close_evt;
  logic             last_adv;
  logic [LVL_W-1:0] slot_now;

  assign load_evt    = pfx_vld && !flush;
  assign adv_evt     = enq_vld && !pfx_vld && !flush;
  assign capture_evt = load_evt && !win_open;
  assign close_evt   = last_adv || (flush && win_open);

  ipl_slot_seq #(.LVL_W(LVL_W), .SLOTS(SLOTS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .load_imm (pfx_imm),
    .advance  (adv_evt),
    .kill     (flush),
    .active   (win_open),
    .cur_lvl  (slot_now),
    .last_adv (last_adv)
  );

  ipl_save_restore #(.LVL_W(LVL_W)) u_save (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (capture_evt),
    .lvl_in      (arch_lvl),
    .close_evt   (close_evt),
    .restore_vld (restore_vld),
    .restore_lvl (restore_lvl)
  );

  assign eff_lvl = win_open ? slot_now : arch_lvl;

  ipl_irq_gate #(.LVL_W(LVL_W)) u_gate (
    .irq_vld  (irq_vld),
    .irq_prio (irq_prio),
    .nmi      (nmi),
    .mask_lvl (eff_lvl),
    .take     (irq_take)
  );
endmodule

// File: rtl/ipl_window_chk.sv
module ipl_window_chk #(
  parameter int unsigned LVL_W = ipl_pkg::LVL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pfx_vld,
  input logic             enq_vld,
  input logic             flush,
  input logic             irq_vld,
  input logic [LVL_W-1:0] irq_prio,
  input logic             nmi,
  input logic [LVL_W-1:0] eff_lvl,
  input logic             win_open,
  input logic             restore_vld,
  input logic             irq_take,
  input logic             close_evt
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !win_open && !restore_vld); // R1
  AST_PFX_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_vld && !flush |=> win_open); // R3
  AST_CLOSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(win_open) |-> $past(flush || (enq_vld && !pfx_vld))); // R4
  AST_PULSE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> restore_vld && !win_open); // R5
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    restore_vld |=> !restore_vld); // R5
  AST_FLUSH_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !win_open); // R8
  AST_NMI_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> irq_take); // R9
  AST_MASKED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi && (!irq_vld || irq_prio <= eff_lvl) |-> !irq_take); // R9
endmodule

bind ipl_override_window ipl_window_chk #(.LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pfx_vld     (pfx_vld),
  .enq_vld     (enq_vld),
  .flush       (flush),
  .irq_vld     (irq_vld),
  .irq_prio    (irq_prio),
  .nmi         (nmi),
  .eff_lvl     (eff_lvl),
  .win_open    (win_open),
  .restore_vld (restore_vld),
  .irq_take    (irq_take),
  .close_evt   (close_evt)
);

// File: tb/test_ipl_override_window.sv
module test_ipl_override_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pfx_vld = 1'b0;
  logic [32:0] pfx_imm = '0;
  logic        enq_vld = 1'b0;
  logic [2:0]  arch_lvl = 3'd0;
  logic        flush = 1'b0;
  logic        irq_vld = 1'b0;
  logic [2:0]  irq_prio = 3'd0;
  logic        nmi = 1'b0;
  logic [2:0]  eff_lvl;
  logic        win_open;
  logic        restore_vld;
  logic [2:0]  restore_lvl;
  logic        irq_take;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string tag = "R1";

  // reference model state
  int q_lvl[$];
  int m_saved = 0;
  bit m_rv = 0;
  int m_rl = 0;

  ipl_override_window i_ipl_override_window (
    .clk(clk), .rst_n(rst_n), .pfx_vld(pfx_vld), .pfx_imm(pfx_imm),
    .enq_vld(enq_vld), .arch_lvl(arch_lvl), .flush(flush),
    .irq_vld(irq_vld), .irq_prio(irq_prio), .nmi(nmi),
    .eff_lvl(eff_lvl), .win_open(win_open), .restore_vld(restore_vld),
    .restore_lvl(restore_lvl), .irq_take(irq_take)
  );

  always #5 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      summary();
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive inputs, compare at mid-cycle, then advance model at edge
  task automatic cyc(bit p, logic [32:0] imm, bit e, int a, bit f);
    int exp_lvl;
    bit exp_take;
    @(negedge clk);
    pfx_vld = p; pfx_imm = imm; enq_vld = e; arch_lvl = 3'(a); flush = f;
    irq_vld = 1'($urandom); irq_prio = 3'($urandom); nmi = ($urandom % 8) == 0;
    #1;
    exp_lvl  = (q_lvl.size() > 0) ? q_lvl[0] : a;
    exp_take = nmi || (irq_vld && int'(irq_prio) > exp_lvl);
    chk("eff_lvl", eff_lvl, exp_lvl);
    chk("win_open", win_open, q_lvl.size() > 0);
    chk("restore_vld", restore_vld, m_rv);
    if (m_rv) chk("restore_lvl", restore_lvl, m_rl);
    chk("irq_take R9", irq_take, exp_take);
    @(posedge clk);
    if (!rst_n) begin
      q_lvl.delete(); m_rv = 0;
    end else if (f) begin
      m_rv = q_lvl.size() > 0; m_rl = m_saved; q_lvl.delete();
    end else if (p) begin
      if (q_lvl.size() == 0) m_saved = a;
      q_lvl.delete();
      for (int k = 0; k < 11; k++) q_lvl.push_back(int'((imm >> (3 * k)) & 33'd7));
      m_rv = 0;
    end else if (e && q_lvl.size() > 0) begin
      void'(q_lvl.pop_front());
      m_rv = q_lvl.size() == 0; m_rl = m_saved;
    end else m_rv = 0;
  endtask

  initial begin
    tag = "R1";
    cyc(0, 0, 0, 3, 0);
    cyc(0, 0, 0, 5, 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 0, 0, 2, 0);

    tag = "R2";
    for (int i = 0; i < 8; i++) cyc(0, 0, i % 2, i, 0);

    tag = "R3";
    cyc(1, 33'o76543210765, 0, 2, 0);
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 4, 0);
    tag = "R4";
    cyc(0, 0, 1, 6, 0);   // eleventh slot
    tag = "R5";
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 1, 1, 0);

    tag = "R6";
    cyc(1, 33'o12345671234, 1, 3, 0);
    for (int i = 0; i < 22; i++) cyc(0, 0, i % 2, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0);

    tag = "R7";
    cyc(1, 33'o77777777777, 0, 4, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 0);
    cyc(1, 33'o01020304050, 0, 6, 0);
    for (int i = 0; i < 12; i++) cyc(0, 0, 1, 2, 0);
    cyc(0, 0, 0, 2, 0);

    tag = "R8";
    cyc(1, 33'o33333333333, 0, 5, 0);
    cyc(0, 0, 1, 1, 0);
    cyc(0, 0, 1, 1, 1);
    cyc(0, 0, 1, 1, 0);
    cyc(0, 0, 1, 1, 0);
    cyc(1, 33'o44444444444, 1, 2, 1);   // flush beats prefix, no window
    cyc(0, 0, 1, 2, 0);
    cyc(0, 0, 0, 2, 0);

    tag = "R9";
    cyc(1, 33'o77777777777, 0, 0, 0);
    for (int i = 0; i < 40; i++) cyc(0, 0, (i % 4) == 0, 0, 0);
    for (int i = 0; i < 40; i++) cyc(0, 0, 0, i % 8, 0);

    summary();
  end
endmodule